// File: doc/BRIEF.md
# Controller-to-Host Mailbox and Interrupt Source Unit

This unit passes one byte at a time from an embedded controller to a host and raises a host interrupt request for it. It has two byte-wide register ports, one for the controller and one for the host. Each port has an address, write data, a write strobe, a read strobe and read data. Inside are three registers. The first holds the message byte. The second collects interrupt sources: a message-pending flag in bit 0 and seven firmware-raised interrupt bits in bits 7:1. The third is an enable mask with one bit for each source.

The controller posts a message by writing the byte. This sets the pending flag. The host takes the message by reading the byte, and that read drops the flag. The controller sets and clears the firmware interrupt bits directly. The host acknowledges them by writing ones to the bits it wants cleared. The host request line is a registered level. It stays high while any enabled source bit is set.

Top module: `host_mbox_irq`

## Requirements
- R1: A controller write to offset 4h stores the byte in the message register and sets the pending flag, which is bit 0 of the source register at offset 8h.
- R2: A controller write of FFh to offset 4h leaves the message register at 00h and still sets the pending flag.
- R3: A host read of offset 4h returns the message byte and clears the pending flag. If a controller write to offset 4h falls in the same cycle, the flag stays set.
- R4: The pending flag cannot be changed from the host port, and the controller can neither see nor change it. Controller reads of offset 8h return 0 in bit 0, and controller writes ignore bit 0.
- R5: The controller reads and writes source bits 7:1 at offset 8h directly.
- R6: A host write to offset 8h clears each of bits 7:1 whose data bit is 1 and leaves each bit whose data bit is 0. If a controller write to offset 8h falls in the same cycle, the controller's value wins.
- R7: The mask at offset Ch is read/write from the controller and readable from the host, and host writes to it are ignored. Mask bit i enables source bit i.
- R8: `host_irq` is registered. From the clock edge that updates the registers, it equals the OR of (source AND mask), and it stays high until every enabled source bit is cleared.
- R9: Reset clears the message byte, all source bits, the mask and `host_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ec_addr | input | 4 | Controller register offset |
| ec_wdata | input | 8 | Controller write data |
| ec_wr | input | 1 | Controller write strobe |
| ec_rd | input | 1 | Controller read strobe |
| ec_rdata | output | 8 | Controller read data (combinational, 0 when not reading) |
| hp_addr | input | 4 | Host register offset |
| hp_wdata | input | 8 | Host write data |
| hp_wr | input | 1 | Host write strobe |
| hp_rd | input | 1 | Host read strobe |
| hp_rdata | output | 8 | Host read data (combinational, 0 when not reading) |
| host_irq | output | 1 | Registered host interrupt request level |

## Verification
Two pairs of operations can collide in one cycle: a controller message write with a host read of the message, and a controller write of the source register with a host write-one-to-clear of it. The bench drives both ports in the same cycle to create each collision. It then reads the source register from the host and expects the pending flag to be set in the first case and the controller's value to be present in the second. It also checks that the host read in the colliding cycle returned the old message byte.

// File: rtl/host_mbox_irq.sv
module host_mbox_irq #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] MBOX_OFS = 4'h4,
  parameter logic [AW-1:0] SRC_OFS  = 4'h8,
  parameter logic [AW-1:0] MASK_OFS = 4'hC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ec_addr,
  input  logic [DW-1:0] ec_wdata,
  input  logic          ec_wr,
  input  logic          ec_rd,
  output logic [DW-1:0] ec_rdata,
  input  logic [AW-1:0] hp_addr,
  input  logic [DW-1:0] hp_wdata,
  input  logic          hp_wr,
  input  logic          hp_rd,
  output logic [DW-1:0] hp_rdata,
  output logic          host_irq
);
  localparam logic [DW-1:0] CLR_VAL = '1;

  logic [DW-1:0] mbox_q, mask_q, mask_d;
  logic [DW-1:1] swi_q, swi_d;
  logic          flag_q, flag_d, irq_q;

  wire ec_mb_wr  = ec_wr && (ec_addr == MBOX_OFS);
  wire ec_src_wr = ec_wr && (ec_addr == SRC_OFS);
  wire ec_msk_wr = ec_wr && (ec_addr == MASK_OFS);
  wire hp_mb_rd  = hp_rd && (hp_addr == MBOX_OFS);
  wire hp_src_wr = hp_wr && (hp_addr == SRC_OFS);

  assign flag_d = ec_mb_wr | (flag_q & ~hp_mb_rd);
  assign mask_d = ec_msk_wr ? ec_wdata : mask_q;

  always_comb begin
    if (ec_src_wr)      swi_d = ec_wdata[DW-1:1];
    else if (hp_src_wr) swi_d = swi_q & ~hp_wdata[DW-1:1];
    else                swi_d = swi_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbox_q <= '0;
      mask_q <= '0;
      swi_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ec_mb_wr) mbox_q <= (ec_wdata == CLR_VAL) ? '0 : ec_wdata;
      mask_q <= mask_d;
      swi_q  <= swi_d;
      flag_q <= flag_d;
      irq_q  <= |({swi_d, flag_d} & mask_d);
    end
  end

  assign host_irq = irq_q;

  always_comb begin
    ec_rdata = '0;
    if (ec_rd) begin
      case (ec_addr)
        MBOX_OFS: ec_rdata = mbox_q;
        SRC_OFS:  ec_rdata = {swi_q, 1'b0};
        MASK_OFS: ec_rdata = mask_q;
        default:  ec_rdata = '0;
      endcase
    end
  end

  always_comb begin
    hp_rdata = '0;
    if (hp_rd) begin
      case (hp_addr)
        MBOX_OFS: hp_rdata = mbox_q;
        SRC_OFS:  hp_rdata = {swi_q, flag_q};
        MASK_OFS: hp_rdata = mask_q;
        default:  hp_rdata = '0;
      endcase
    end
  end

  p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ec_mb_wr |=> flag_q);

  p_clear_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ec_mb_wr && ec_wdata == CLR_VAL) |=> (mbox_q == '0));

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_mb_rd && !ec_mb_wr) |=> !flag_q);

  p_flag_guarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ec_mb_wr && !hp_mb_rd) |=> $stable(flag_q));

  p_ec_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ec_src_wr |=> (swi_q == $past(ec_wdata[DW-1:1])));

  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_src_wr && !ec_src_wr) |=> ((swi_q & $past(hp_wdata[DW-1:1])) == '0));

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == |({swi_q, flag_q} & mask_q));

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_irq && !hp_mb_rd && !ec_wr && !hp_src_wr) |=> host_irq);
endmodule

// File: tb/test_host_mbox_irq.sv
module test_host_mbox_irq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ec_addr = '0, hp_addr = '0;
  logic [7:0] ec_wdata = '0, hp_wdata = '0;
  logic       ec_wr = 1'b0, ec_rd = 1'b0, hp_wr = 1'b0, hp_rd = 1'b0;
  logic [7:0] ec_rdata, hp_rdata;
  logic       host_irq;

  int checks = 0, errors = 0;
  logic  done = 1'b0;
  event  chk_ev;
  logic [7:0] exp_q[$];
  int         sel_q[$];
  string      req_q[$];

  host_mbox_irq i_host_mbox_irq (
    .clk(clk), .rst_n(rst_n),
    .ec_addr(ec_addr), .ec_wdata(ec_wdata), .ec_wr(ec_wr), .ec_rd(ec_rd), .ec_rdata(ec_rdata),
    .hp_addr(hp_addr), .hp_wdata(hp_wdata), .hp_wr(hp_wr), .hp_rd(hp_rd), .hp_rdata(hp_rdata),
    .host_irq(host_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [7:0] act, exp;
        int sel;
        string req;
        exp = exp_q.pop_front();
        sel = sel_q.pop_front();
        req = req_q.pop_front();
        act = (sel == 0) ? hp_rdata : (sel == 1) ? ec_rdata : {7'd0, host_irq};
        checks++;
        if (act !== exp) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
      end
    end
  end

  task automatic expect_now(int sel, logic [7:0] exp, string req);
    exp_q.push_back(exp);
    sel_q.push_back(sel);
    req_q.push_back(req);
    #1 -> chk_ev;
    #1;
  endtask

  task automatic step(logic [3:0] ea, logic [7:0] ed, logic ew, logic er,
                      logic [3:0] ha, logic [7:0] hd, logic hw, logic hr);
    @(negedge clk);
    ec_addr = ea; ec_wdata = ed; ec_wr = ew; ec_rd = er;
    hp_addr = ha; hp_wdata = hd; hp_wr = hw; hp_rd = hr;
  endtask

  task automatic idle();
    step(4'h0, 8'h00, 1'b0, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic ec_write(logic [3:0] a, logic [7:0] d);
    step(a, d, 1'b1, 1'b0, 4'h0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic hp_write(logic [3:0] a, logic [7:0] d);
    step(4'h0, 8'h00, 1'b0, 1'b0, a, d, 1'b1, 1'b0);
  endtask

  task automatic hp_read(logic [3:0] a, logic [7:0] exp, string req);
    step(4'h0, 8'h00, 1'b0, 1'b0, a, 8'h00, 1'b0, 1'b1);
    expect_now(0, exp, req);
  endtask

  task automatic ec_read(logic [3:0] a, logic [7:0] exp, string req);
    step(a, 8'h00, 1'b0, 1'b1, 4'h0, 8'h00, 1'b0, 1'b0);
    expect_now(1, exp, req);
  endtask

  task automatic irq_is(logic v, string req);
    idle();
    expect_now(2, {7'd0, v}, req);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    hp_read(4'h4, 8'h00, "R9 mailbox after reset");
    hp_read(4'h8, 8'h00, "R9 source after reset");
    ec_read(4'hC, 8'h00, "R9 mask after reset");
    irq_is(1'b0, "R9 irq after reset");

    ec_write(4'h4, 8'h5A);
    hp_read(4'h8, 8'h01, "R1 flag set by message write");
    hp_read(4'h4, 8'h5A, "R1 message byte");
    hp_read(4'h8, 8'h00, "R3 host read clears flag");

    ec_write(4'hC, 8'h01);
    irq_is(1'b0, "R8 no source no irq");
    ec_write(4'h4, 8'h33);
    irq_is(1'b1, "R8 irq on enabled flag");
    ec_read(4'hC, 8'h01, "R7 mask readback");
    hp_write(4'hC, 8'h00);
    ec_read(4'hC, 8'h01, "R7 host mask write ignored");
    hp_read(4'hC, 8'h01, "R7 host reads mask");
    hp_write(4'h8, 8'h01);
    hp_read(4'h8, 8'h01, "R4 host cannot clear flag");
    irq_is(1'b1, "R8 irq holds while flag set");
    ec_read(4'h8, 8'h00, "R4 controller sees no flag");
    hp_read(4'h4, 8'h33, "R3 message read");
    irq_is(1'b0, "R8 irq drops after flag cleared");
    ec_write(4'h8, 8'h01);
    hp_read(4'h8, 8'h00, "R4 controller cannot set flag");

    ec_write(4'h8, 8'hA4);
    ec_read(4'h8, 8'hA4, "R5 controller readback");
    hp_read(4'h8, 8'hA4, "R5 host sees sw bits");
    irq_is(1'b0, "R7 masked bits raise no irq");
    ec_write(4'hC, 8'h80);
    irq_is(1'b1, "R7 enabled bit7 raises irq");
    hp_write(4'h8, 8'h24);
    hp_read(4'h8, 8'h80, "R6 only ones clear");
    irq_is(1'b1, "R8 irq holds on bit7");
    hp_write(4'h8, 8'h80);
    hp_read(4'h8, 8'h00, "R6 clear last bit");
    irq_is(1'b0, "R8 irq drops");

    step(4'h8, 8'hFE, 1'b1, 1'b0, 4'h8, 8'hFE, 1'b1, 1'b0);
    hp_read(4'h8, 8'hFE, "R6 controller write wins collision");
    irq_is(1'b1, "R8 irq after collision");

    ec_write(4'h4, 8'hFF);
    hp_read(4'h8, 8'hFF, "R2 FF write still sets flag");
    hp_read(4'h4, 8'h00, "R2 FF clears message");
    hp_read(4'h8, 8'hFE, "R3 flag cleared after read");

    step(4'h4, 8'h11, 1'b1, 1'b0, 4'h4, 8'h00, 1'b0, 1'b1);
    expect_now(0, 8'h00, "R3 colliding read returns old byte");
    hp_read(4'h8, 8'hFF, "R3 collision keeps flag set");
    hp_read(4'h4, 8'h11, "R1 new message after collision");

    @(negedge clk) rst_n = 1'b0;
    idle();
    @(negedge clk) rst_n = 1'b1;
    hp_read(4'h8, 8'h00, "R9 source cleared by reset");
    hp_read(4'hC, 8'h00, "R9 mask cleared by reset");
    hp_read(4'h4, 8'h00, "R9 mailbox cleared by reset");
    irq_is(1'b0, "R9 irq cleared by reset");

    idle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule